// File: doc/BRIEF.md
# Voltage/Frequency Transition Sequencer

This block moves a core from one voltage/frequency operating point to another in a safe order. It holds a small programmable table in which each entry pairs a PLL frequency code with a regulator VID code. A transition starts on a thermal trigger or on a software request, and each request names a table index. When the new point has a lower supply, the sequencer halts execution, asks the PLL to relock at the new frequency and waits for lock. It then releases the halt and walks the VID output down one code at a time. When the new point has a higher supply, it first walks the VID up to the target and only then halts execution for the PLL relock.

The VID output never jumps. Each step changes it by one code, and consecutive steps are spaced by a programmable wait that stands for the regulator slew limit. Requests that arrive during a transition are held in a single pending slot, and a later request overwrites an earlier one. A request for the point already in use finishes at once, with no halt and no relock. The PLL and the regulator lie outside the block. It only drives their targets and watches the lock handshake.

Top module: `vfs_seq_top`

## Requirements
- R1: After reset, `vid_o` equals the parameter `RST_VID`, `pll_freq_o` equals `RST_FREQ`, and `cur_idx_o` is 0. `halt_o`, `pll_req_o`, `busy_o` and `done_o` are all low.
- R2: When the target VID code is not greater than the current one (a downward move), `halt_o` and `pll_req_o` rise and `pll_freq_o` shows the target frequency code before the VID changes at all. The VID ramp starts only after the halt has been released.
- R3: When the target VID code is greater than the current one (an upward move), the VID reaches its target before `pll_req_o` rises. The frequency relock comes last.
- R4: `halt_o` and `pll_req_o` stay high until `pll_lock_i` is seen, and they drop in the cycle after the first cycle in which lock is high. With a PLL that reports lock on its Nth requested cycle, the halt lasts exactly N cycles.
- R5: VID codes are linear and a higher code means a higher supply; one code is one 25 mV step. Every change of `vid_o` is exactly plus or minus one code. Consecutive changes within one ramp are exactly `step_wait_i`+1 cycles apart.
- R6: `vid_o` never changes while `halt_o` is high.
- R7: A request whose index equals `cur_idx_o` completes with one `done_o` pulse. It raises no halt and no PLL request, and it leaves `vid_o` unchanged.
- R8: Each accepted request produces exactly one single-cycle `done_o` pulse while `busy_o` is high. `cur_idx_o` already shows the new index in that cycle.
- R9: A request that arrives while `busy_o` is high is held and serviced after the current transition. A later held request replaces an earlier one, so only the newest is serviced.
- R10: If a thermal request and a software request arrive in the same cycle, the thermal index is taken and the software request is discarded.
- R11: The table is written through `cfg_we_i`, `cfg_idx_i`, `cfg_freq_i` (one frequency code is one 33 MHz step) and `cfg_vid_i`. The target is captured when the request is accepted, so writing an entry during a transition does not change that transition. A later request to the entry uses the new values.
- R12: When `done_o` pulses, `vid_o` and `pll_freq_o` equal the VID and frequency codes of the requested table entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_idx_i | input | IDX_W | Table entry to write |
| cfg_freq_i | input | FREQ_W | Frequency code to store |
| cfg_vid_i | input | VID_W | VID code to store |
| step_wait_i | input | WAIT_W | Extra cycles between VID steps |
| therm_req_i | input | 1 | Thermal trigger request |
| therm_idx_i | input | IDX_W | Target index of the thermal request |
| sw_req_i | input | 1 | Software request |
| sw_idx_i | input | IDX_W | Target index of the software request |
| pll_lock_i | input | 1 | PLL reports lock at the requested frequency |
| halt_o | output | 1 | Stop core execution |
| pll_req_o | output | 1 | Ask the PLL to relock at `pll_freq_o` |
| pll_freq_o | output | FREQ_W | Frequency code for the PLL |
| vid_o | output | VID_W | VID code for the regulator |
| busy_o | output | 1 | A transition is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cur_idx_o | output | IDX_W | Operating point now in use |

## Verification
Two pairs of events can fall in the same cycle, and both are provoked on purpose. In the first, a new request lands while a transition is running. The bench sends two such requests at different cycles of one transition and expects exactly two completions, with the newest index reached at the end. It also expects no further activity afterwards. In the second, a thermal and a software request are raised on the same clock edge. The bench expects a single transition to the thermal index and expects the software request to leave no trace once the block returns to idle.

// File: rtl/vfs_pkg.sv
package vfs_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HALT = 2'd1,
      ST_RAMP = 2'd2,
      ST_FIN  = 2'd3
   } vfs_state_e;

   typedef enum logic [1:0] {
      DIR_SAME = 2'd0,
      DIR_DOWN = 2'd1,
      DIR_UP   = 2'd2
   } vfs_dir_e;

endpackage

// File: rtl/vfs_optable.sv
module vfs_optable #(
   parameter int N_PTS    = 8,
   parameter int IDX_W    = 3,
   parameter int FREQ_W   = 8,
   parameter int VID_W    = 7,
   parameter int RST_FREQ = 30,
   parameter int RST_VID  = 40
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [IDX_W-1:0]  wr_idx_i,
   input  logic [FREQ_W-1:0] wr_freq_i,
   input  logic [VID_W-1:0]  wr_vid_i,
   input  logic [IDX_W-1:0]  rd_idx_i,
   output logic [FREQ_W-1:0] rd_freq_o,
   output logic [VID_W-1:0]  rd_vid_o
);

   localparam logic [FREQ_W-1:0] FREQ_INIT = FREQ_W'(RST_FREQ);
   localparam logic [VID_W-1:0]  VID_INIT  = VID_W'(RST_VID);

   logic [FREQ_W-1:0] freq_q [N_PTS];
   logic [VID_W-1:0]  vid_q  [N_PTS];

   for (genvar e = 0; e < N_PTS; e++) begin : g_entry
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            freq_q[e] <= FREQ_INIT;
            vid_q[e]  <= VID_INIT;
         end else if (wr_en_i && (wr_idx_i == IDX_W'(e))) begin
            freq_q[e] <= wr_freq_i;
            vid_q[e]  <= wr_vid_i;
         end
      end
   end

   assign rd_freq_o = freq_q[rd_idx_i];
   assign rd_vid_o  = vid_q[rd_idx_i];

endmodule

// File: rtl/vfs_req_arb.sv
module vfs_req_arb #(
   parameter int IDX_W       = 3,
   parameter bit THERM_FIRST = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             therm_req_i,
   input  logic [IDX_W-1:0] therm_idx_i,
   input  logic             sw_req_i,
   input  logic [IDX_W-1:0] sw_idx_i,
   input  logic             take_i,
   output logic             go_o,
   output logic [IDX_W-1:0] go_idx_o
);

   logic             new_v;
   logic [IDX_W-1:0] new_idx;
   logic             pend_v_q;
   logic [IDX_W-1:0] pend_idx_q;

   assign new_v = therm_req_i | sw_req_i;

   if (THERM_FIRST) begin : g_therm_first
      assign new_idx = therm_req_i ? therm_idx_i : sw_idx_i;
   end else begin : g_sw_first
      assign new_idx = sw_req_i ? sw_idx_i : therm_idx_i;
   end

   assign go_o     = take_i & (pend_v_q | new_v);
   assign go_idx_o = pend_v_q ? pend_idx_q : new_idx;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_v_q   <= 1'b0;
         pend_idx_q <= '0;
      end else if (take_i) begin
         if (pend_v_q && new_v) begin
            pend_idx_q <= new_idx;
         end else begin
            pend_v_q <= 1'b0;
         end
      end else if (new_v) begin
         pend_v_q   <= 1'b1;
         pend_idx_q <= new_idx;
      end
   end

endmodule

// File: rtl/vfs_vid_ramp.sv
module vfs_vid_ramp #(
   parameter int VID_W   = 7,
   parameter int WAIT_W  = 8,
   parameter int RST_VID = 40
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_i,
   input  logic [VID_W-1:0]  tgt_i,
   input  logic [WAIT_W-1:0] wait_i,
   output logic [VID_W-1:0]  vid_o,
   output logic              at_tgt_o
);

   localparam logic [VID_W-1:0] VID_INIT = VID_W'(RST_VID);

   logic [VID_W-1:0]  vid_q;
   logic [WAIT_W-1:0] cnt_q;

   assign at_tgt_o = (vid_q == tgt_i);
   assign vid_o    = vid_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         vid_q <= VID_INIT;
         cnt_q <= '0;
      end else if (!en_i || at_tgt_o) begin
         cnt_q <= '0;
      end else if (cnt_q == wait_i) begin
         cnt_q <= '0;
         vid_q <= (tgt_i > vid_q) ? vid_q + 1'b1 : vid_q - 1'b1;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R5
   step_size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vid_q != $past(vid_q)) |->
         ((vid_q == $past(vid_q) + 1'b1) || (vid_q == $past(vid_q) - 1'b1)));

   // R5
   step_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vid_q != $past(vid_q)) |-> ($past(cnt_q) == $past(wait_i)));

endmodule

// File: rtl/vfs_seq_fsm.sv
module vfs_seq_fsm
   import vfs_pkg::*;
#(
   parameter int IDX_W    = 3,
   parameter int FREQ_W   = 8,
   parameter int VID_W    = 7,
   parameter int RST_FREQ = 30
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              go_i,
   input  logic [IDX_W-1:0]  go_idx_i,
   input  logic [FREQ_W-1:0] rd_freq_i,
   input  logic [VID_W-1:0]  rd_vid_i,
   input  logic [VID_W-1:0]  vid_i,
   input  logic              at_tgt_i,
   input  logic              pll_lock_i,
   output logic              take_o,
   output logic              ramp_en_o,
   output logic [VID_W-1:0]  tgt_vid_o,
   output logic              halt_o,
   output logic              pll_req_o,
   output logic [FREQ_W-1:0] pll_freq_o,
   output logic              busy_o,
   output logic              done_o,
   output logic [IDX_W-1:0]  cur_idx_o
);

   localparam logic [FREQ_W-1:0] FREQ_INIT = FREQ_W'(RST_FREQ);

   vfs_state_e        state_q, state_d;
   vfs_dir_e          dir_q;
   logic [IDX_W-1:0]  tgt_idx_q;
   logic [VID_W-1:0]  tgt_vid_q;
   logic [FREQ_W-1:0] tgt_freq_q;
   logic [FREQ_W-1:0] pll_freq_q;
   logic [IDX_W-1:0]  cur_idx_q;
   vfs_dir_e          dir_new;

   always_comb begin
      if (go_idx_i == cur_idx_q)   dir_new = DIR_SAME;
      else if (rd_vid_i > vid_i)   dir_new = DIR_UP;
      else                         dir_new = DIR_DOWN;
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (go_i) begin
               unique case (dir_new)
                  DIR_SAME: state_d = ST_FIN;
                  DIR_DOWN: state_d = ST_HALT;
                  default:  state_d = ST_RAMP;
               endcase
            end
         end
         ST_HALT: if (pll_lock_i) state_d = (dir_q == DIR_DOWN) ? ST_RAMP : ST_FIN;
         ST_RAMP: if (at_tgt_i)   state_d = (dir_q == DIR_DOWN) ? ST_FIN : ST_HALT;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q    <= ST_IDLE;
         dir_q      <= DIR_SAME;
         tgt_idx_q  <= '0;
         tgt_vid_q  <= '0;
         tgt_freq_q <= FREQ_INIT;
         pll_freq_q <= FREQ_INIT;
         cur_idx_q  <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && go_i) begin
            dir_q      <= dir_new;
            tgt_idx_q  <= go_idx_i;
            tgt_vid_q  <= rd_vid_i;
            tgt_freq_q <= rd_freq_i;
         end
         if (state_d == ST_HALT && state_q != ST_HALT) begin
            pll_freq_q <= (state_q == ST_IDLE) ? rd_freq_i : tgt_freq_q;
         end
         if (state_d == ST_FIN) begin
            cur_idx_q <= (state_q == ST_IDLE) ? go_idx_i : tgt_idx_q;
         end
      end
   end

   assign take_o     = (state_q == ST_IDLE);
   assign ramp_en_o  = (state_q == ST_RAMP);
   assign tgt_vid_o  = tgt_vid_q;
   assign halt_o     = (state_q == ST_HALT);
   assign pll_req_o  = (state_q == ST_HALT);
   assign pll_freq_o = pll_freq_q;
   assign busy_o     = (state_q != ST_IDLE);
   assign done_o     = (state_q == ST_FIN);
   assign cur_idx_o  = cur_idx_q;

   // R4
   halt_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (halt_o && pll_lock_i) |=> !halt_o);

   // R8
   done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   // R8
   done_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> busy_o);

   // R3
   up_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pll_req_o && dir_q == DIR_UP) |-> at_tgt_i);

   // R2
   down_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ramp_en_o && dir_q == DIR_DOWN) |-> (pll_freq_q == tgt_freq_q));

endmodule

// File: rtl/vfs_seq_top.sv
module vfs_seq_top #(
   parameter int N_PTS       = 8,
   parameter int FREQ_W      = 8,
   parameter int VID_W       = 7,
   parameter int WAIT_W      = 8,
   parameter int RST_FREQ    = 30,
   parameter int RST_VID     = 40,
   parameter bit THERM_FIRST = 1'b1,
   localparam int IDX_W      = (N_PTS > 1) ? $clog2(N_PTS) : 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cfg_we_i,
   input  logic [IDX_W-1:0]  cfg_idx_i,
   input  logic [FREQ_W-1:0] cfg_freq_i,
   input  logic [VID_W-1:0]  cfg_vid_i,
   input  logic [WAIT_W-1:0] step_wait_i,
   input  logic              therm_req_i,
   input  logic [IDX_W-1:0]  therm_idx_i,
   input  logic              sw_req_i,
   input  logic [IDX_W-1:0]  sw_idx_i,
   input  logic              pll_lock_i,
   output logic              halt_o,
   output logic              pll_req_o,
   output logic [FREQ_W-1:0] pll_freq_o,
   output logic [VID_W-1:0]  vid_o,
   output logic              busy_o,
   output logic              done_o,
   output logic [IDX_W-1:0]  cur_idx_o
);

   if (N_PTS < 2 || (1 << IDX_W) != N_PTS) begin : g_bad_pts
      $error("vfs_seq_top: N_PTS must be a power of two, at least 2");
   end
   if (VID_W < 2 || FREQ_W < 2 || WAIT_W < 1) begin : g_bad_w
      $error("vfs_seq_top: field widths too small");
   end
   if (RST_VID < 0 || RST_VID >= (1 << VID_W)) begin : g_bad_rvid
      $error("vfs_seq_top: RST_VID does not fit VID_W");
   end
   if (RST_FREQ < 0 || RST_FREQ >= (1 << FREQ_W)) begin : g_bad_rfreq
      $error("vfs_seq_top: RST_FREQ does not fit FREQ_W");
   end

   logic              take;
   logic              go;
   logic [IDX_W-1:0]  go_idx;
   logic [FREQ_W-1:0] rd_freq;
   logic [VID_W-1:0]  rd_vid;
   logic              ramp_en;
   logic [VID_W-1:0]  tgt_vid;
   logic              at_tgt;
   logic [VID_W-1:0]  vid;

   vfs_optable #(
      .N_PTS(N_PTS), .IDX_W(IDX_W), .FREQ_W(FREQ_W), .VID_W(VID_W),
      .RST_FREQ(RST_FREQ), .RST_VID(RST_VID)
   ) u_table (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .wr_en_i(cfg_we_i), .wr_idx_i(cfg_idx_i),
      .wr_freq_i(cfg_freq_i), .wr_vid_i(cfg_vid_i),
      .rd_idx_i(go_idx), .rd_freq_o(rd_freq), .rd_vid_o(rd_vid)
   );

   vfs_req_arb #(.IDX_W(IDX_W), .THERM_FIRST(THERM_FIRST)) u_arb (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .therm_req_i(therm_req_i), .therm_idx_i(therm_idx_i),
      .sw_req_i(sw_req_i), .sw_idx_i(sw_idx_i),
      .take_i(take), .go_o(go), .go_idx_o(go_idx)
   );

   vfs_vid_ramp #(.VID_W(VID_W), .WAIT_W(WAIT_W), .RST_VID(RST_VID)) u_ramp (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .en_i(ramp_en), .tgt_i(tgt_vid), .wait_i(step_wait_i),
      .vid_o(vid), .at_tgt_o(at_tgt)
   );

   vfs_seq_fsm #(
      .IDX_W(IDX_W), .FREQ_W(FREQ_W), .VID_W(VID_W), .RST_FREQ(RST_FREQ)
   ) u_fsm (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .go_i(go), .go_idx_i(go_idx),
      .rd_freq_i(rd_freq), .rd_vid_i(rd_vid),
      .vid_i(vid), .at_tgt_i(at_tgt), .pll_lock_i(pll_lock_i),
      .take_o(take), .ramp_en_o(ramp_en), .tgt_vid_o(tgt_vid),
      .halt_o(halt_o), .pll_req_o(pll_req_o), .pll_freq_o(pll_freq_o),
      .busy_o(busy_o), .done_o(done_o), .cur_idx_o(cur_idx_o)
   );

   assign vid_o = vid;

   // R6
   halt_vid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (halt_o && $past(halt_o)) |-> $stable(vid));

endmodule

// File: tb/vfs_seq_top_tb_top.sv
module vfs_seq_top_tb_top;

   localparam int LOCK_DLY = 3;

   // vector fields: {idx[3], dir[2] (0 same, 1 down, 2 up), vid[7], freq[8]}
   localparam logic [19:0] VEC [5] = '{
      {3'd1, 2'd1, 7'd34, 8'd24},
      {3'd2, 2'd2, 7'd46, 8'd36},
      {3'd2, 2'd0, 7'd46, 8'd36},
      {3'd3, 2'd1, 7'd20, 8'd10},
      {3'd0, 2'd2, 7'd40, 8'd30}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [2:0] cfg_idx = '0;
   logic [7:0] cfg_freq = '0;
   logic [6:0] cfg_vid = '0;
   logic [7:0] step_wait = 8'd2;
   logic       therm_req = 1'b0;
   logic [2:0] therm_idx = '0;
   logic       sw_req = 1'b0;
   logic [2:0] sw_idx = '0;
   logic       pll_lock = 1'b0;
   logic       halt, pll_req, busy, done;
   logic [7:0] pll_freq;
   logic [6:0] vid;
   logic [2:0] cur_idx;

   vfs_seq_top dut_i (
      .clk_i(clk), .rst_ni(rst_n),
      .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_freq_i(cfg_freq), .cfg_vid_i(cfg_vid),
      .step_wait_i(step_wait),
      .therm_req_i(therm_req), .therm_idx_i(therm_idx),
      .sw_req_i(sw_req), .sw_idx_i(sw_idx),
      .pll_lock_i(pll_lock),
      .halt_o(halt), .pll_req_o(pll_req), .pll_freq_o(pll_freq), .vid_o(vid),
      .busy_o(busy), .done_o(done), .cur_idx_o(cur_idx)
   );

   always #5 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   // PLL model: lock on the LOCK_DLY-th requested cycle
   int pcnt = 0;
   always @(negedge clk) begin
      if (pll_req) begin
         pcnt = pcnt + 1;
         pll_lock = (pcnt >= LOCK_DLY);
      end else begin
         pcnt = 0;
         pll_lock = 1'b0;
      end
   end

   // transaction monitor
   bit         mon_en = 1'b0;
   int         t, t_pll, t_vfirst, t_vlast, gap_bad, halt_n, done_n, vhalt;
   logic [6:0] prev_vid;

   always @(negedge clk) begin
      if (mon_en) begin
         t++;
         if (pll_req && t_pll < 0) t_pll = t;
         if (vid != prev_vid) begin
            if (halt) vhalt++;
            if (t_vlast >= 0 && (t - t_vlast) != int'(step_wait) + 1) gap_bad++;
            if (t_vfirst < 0) t_vfirst = t;
            t_vlast = t;
         end
         prev_vid = vid;
         halt_n += int'(halt);
         done_n += int'(done);
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic prog(input logic [2:0] idx, input logic [7:0] f, input logic [6:0] v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = idx; cfg_freq = f; cfg_vid = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic run_tx(input bit th, input logic [2:0] idx);
      int n;
      @(posedge clk);
      #1;
      t = 0; t_pll = -1; t_vfirst = -1; t_vlast = -1;
      gap_bad = 0; halt_n = 0; done_n = 0; vhalt = 0;
      prev_vid = vid; mon_en = 1'b1;
      @(negedge clk);
      if (th) begin therm_req = 1'b1; therm_idx = idx; end
      else    begin sw_req = 1'b1;    sw_idx = idx;    end
      n = 0;
      do begin
         @(negedge clk);
         therm_req = 1'b0; sw_req = 1'b0;
         n++;
      end while (!done && n < 3000);
      chk(n < 3000, "R8 timeout", n, 3000);
      @(negedge clk);
      mon_en = 1'b0;
   endtask

   task automatic wait_dones(input int want, output logic [2:0] first_idx);
      int seen = 0;
      int n = 0;
      first_idx = '0;
      while (seen < want && n < 5000) begin
         @(negedge clk);
         therm_req = 1'b0; sw_req = 1'b0;
         if (done) begin
            if (seen == 0) first_idx = cur_idx;
            seen++;
         end
         n++;
      end
      chk(seen == want, "R9 done count", seen, want);
   endtask

   task automatic idle_watch(input string req);
      int b = 0;
      for (int k = 0; k < 30; k++) begin
         @(negedge clk);
         b += int'(busy);
      end
      chk(b == 0, req, b, 0);
   endtask

   initial begin
      logic [2:0] fidx;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(vid == 7'd40, "R1 vid", int'(vid), 40);
      chk(pll_freq == 8'd30, "R1 freq", int'(pll_freq), 30);
      chk(cur_idx == 3'd0 && !halt && !pll_req && !busy && !done, "R1 flags",
          int'({cur_idx, halt, pll_req, busy, done}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(vid == 7'd40 && !busy && !halt, "R1 after release", int'(vid), 40);

      // R11: program the table
      prog(3'd0, 8'd30, 7'd40);
      prog(3'd1, 8'd24, 7'd34);
      prog(3'd2, 8'd36, 7'd46);
      prog(3'd3, 8'd10, 7'd20);

      // vector walk
      step_wait = 8'd2;
      for (int i = 0; i < 5; i++) begin
         run_tx(1'b0, VEC[i][19:17]);
         chk(vid == VEC[i][14:8], "R12 vid", int'(vid), int'(VEC[i][14:8]));
         chk(pll_freq == VEC[i][7:0], "R12 freq", int'(pll_freq), int'(VEC[i][7:0]));
         chk(cur_idx == VEC[i][19:17], "R8 cur_idx", int'(cur_idx), int'(VEC[i][19:17]));
         chk(done_n == 1, "R8 done pulses", done_n, 1);
         chk(gap_bad == 0, "R5 step spacing", gap_bad, 0);
         chk(vhalt == 0, "R6 vid during halt", vhalt, 0);
         case (VEC[i][16:15])
            2'd0: chk(halt_n == 0 && t_pll < 0 && t_vfirst < 0, "R7 same point",
                      halt_n, 0);
            2'd1: begin
               chk(halt_n == LOCK_DLY, "R4 halt length", halt_n, LOCK_DLY);
               chk(t_pll > 0 && t_vfirst > t_pll, "R2 freq first", t_vfirst, t_pll + 1);
            end
            default: begin
               chk(halt_n == LOCK_DLY, "R4 halt length", halt_n, LOCK_DLY);
               chk(t_vlast > 0 && t_pll > t_vlast, "R3 vid first", t_pll, t_vlast + 1);
            end
         endcase
      end

      // R5: step spacing with different waits (20 codes, 19 gaps)
      step_wait = 8'd0;
      run_tx(1'b0, 3'd3);
      chk(t_vlast - t_vfirst == 19, "R5 wait0 span", t_vlast - t_vfirst, 19);
      chk(vid == 7'd20 && gap_bad == 0, "R5 wait0 end", int'(vid), 20);
      step_wait = 8'd5;
      run_tx(1'b1, 3'd0);
      chk(t_vlast - t_vfirst == 114, "R5 wait5 span", t_vlast - t_vfirst, 114);
      chk(vid == 7'd40 && gap_bad == 0, "R5 wait5 end", int'(vid), 40);

      // R9: two requests while busy, newest wins
      step_wait = 8'd2;
      @(negedge clk);
      sw_req = 1'b1; sw_idx = 3'd1;
      @(negedge clk);
      sw_req = 1'b0;
      repeat (3) @(negedge clk);
      chk(busy == 1'b1, "R9 busy before pend", int'(busy), 1);
      sw_req = 1'b1; sw_idx = 3'd3;
      @(negedge clk);
      sw_req = 1'b0;
      repeat (2) @(negedge clk);
      sw_req = 1'b1; sw_idx = 3'd2;
      wait_dones(2, fidx);
      chk(fidx == 3'd1, "R9 first serviced", int'(fidx), 1);
      chk(cur_idx == 3'd2 && vid == 7'd46, "R9 newest serviced", int'(cur_idx), 2);
      idle_watch("R9 no extra transition");

      // R10: thermal and software together
      @(negedge clk);
      therm_req = 1'b1; therm_idx = 3'd3;
      sw_req = 1'b1;    sw_idx = 3'd1;
      wait_dones(1, fidx);
      chk(cur_idx == 3'd3 && vid == 7'd20, "R10 thermal taken", int'(cur_idx), 3);
      idle_watch("R10 software dropped");

      // R11: table write during a transition
      @(negedge clk);
      sw_req = 1'b1; sw_idx = 3'd1;
      @(negedge clk);
      sw_req = 1'b0;
      repeat (4) @(negedge clk);
      cfg_we = 1'b1; cfg_idx = 3'd1; cfg_freq = 8'd50; cfg_vid = 7'd60;
      @(negedge clk);
      cfg_we = 1'b0;
      wait_dones(1, fidx);
      chk(vid == 7'd34 && pll_freq == 8'd24, "R11 captured target", int'(vid), 34);
      run_tx(1'b0, 3'd0);
      run_tx(1'b0, 3'd1);
      chk(vid == 7'd60 && pll_freq == 8'd50, "R11 new entry used", int'(vid), 60);
      chk(halt_n == LOCK_DLY && t_pll > t_vlast, "R3 reprogrammed up", halt_n, LOCK_DLY);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule